// File: doc/BRIEF.md
# Structure Load/Store Lane Transposer

This block sits between a load/store unit and a register file and handles accesses to arrays of small records. Each record is 1 to 4 elements long. Memory holds the records one after another. Software wants one register for each element position: all the first elements packed side by side in one register, all the second elements in the next register, and so on. A load gathers the incoming 64-bit memory beats and writes the destination registers already permuted. No read-permute-write step follows. A store takes register contents and produces memory beats in record order.

A transfer opens with a one-cycle `start` that carries the direction, the element count and the element size. The block then accepts exactly as many 64-bit beats as there are elements per record, under a valid/ready handshake. In the cycle after the last beat it presents all result beats at once on parallel write ports, each with its own strobe, and raises `done`. Gaps in the input stream only delay the transfer.

Top module: `struct_xpose`

## Requirements
- R1: A `start` pulse in the idle state with a size code of 0 (8-bit), 1 (16-bit) or 2 (32-bit) latches the direction, element count (code c means c+1 elements) and size. From the next cycle `in_ready` stays high until that many beats have been accepted.
- R2: In the cycle after the last beat is accepted, `done` is high and `wr_valid[k]` is high for every k below the element count. Both last exactly one cycle, and `in_ready` is low in that cycle.
- R3: Load direction (`store_mode`=0). Input beat 0 carries memory bytes 0..7 and beat 1 carries bytes 8..15, with memory byte 0 in bits 7:0. Element j of record i appears in output k=j, lane i. Lane i occupies bits [i*W +: W], where W is the element width.
- R4: Store direction (`store_mode`=1). Input beat k is register k, with the same lane layout as R3. Output k is memory beat k in the byte order of R3. The record-major element order is rebuilt from lane i of register j.
- R5: With one element per record, both directions copy the input beat unchanged to output 0.
- R6: While `in_valid` is low during a transfer, nothing is consumed, `in_ready` stays high and no strobe rises. Idle gaps between beats leave the result unchanged.
- R7: A `start` with size code 3 is ignored: `in_ready` stays low and no strobe follows.
- R8: A `start` during a transfer is ignored, and so are configuration changes on the pins during a transfer. The transfer completes with its latched configuration.
- R9: Outputs at or above the element count keep their strobe low and their data at zero.
- R10: During reset `in_ready`, `done` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a transfer with the configuration below |
| store_mode | input | 1 | 0 = load (de-interleave), 1 = store (re-interleave) |
| elem_code | input | 2 | Elements per record minus one |
| size_code | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = rejected |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 64 | Input beat |
| wr_valid | output | 4 | Per-output write strobe |
| wr_data | output | 256 | Output beats, output k in bits [k*64 +: 64] |
| done | output | 1 | Transfer complete |

## Verification
The assertions check the handshake and framing on every cycle. `done` must follow an accepted beat and last one cycle, it must coincide with a dropped `in_ready` and with strobes that start at output 0, a stalled transfer keeps its ready, and a rejected size code never opens a transfer. The permutation itself can only be shown by the bench's scenarios. These sweep both directions, every element count and every element size with distinct byte patterns, add stalls and stray `start` pulses, and compare every output lane against element positions computed from the record layout.

// File: rtl/sx_pkg.sv
`timescale 1ns/1ps
package sx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_EMIT = 2'd2
   } xp_state_t;

   localparam logic [1:0] SIZE_BAD = 2'd3;

   // Byte index inside the gathered image that feeds destination byte g.
   // st=0: record-major memory to element-major registers; st=1: inverse.
   function automatic int src_byte(bit st, int n, int sb, int beat_b, int g);
      int lanes, k, b, i, j, off, e, r;
      if (g >= n * beat_b) return 0;
      lanes = beat_b / sb;
      if (!st) begin
         k   = g / beat_b;
         b   = g % beat_b;
         i   = b / sb;
         off = b % sb;
         r   = (i * n + k) * sb + off;
      end else begin
         e   = g / sb;
         off = g % sb;
         i   = e / n;
         j   = e % n;
         r   = (j * lanes + i) * sb + off;
      end
      return r;
   endfunction

endpackage

// File: rtl/sx_ctrl.sv
`timescale 1ns/1ps
module sx_ctrl #(
   parameter int MAX_ELEM = 4,
   localparam int CW = $clog2(MAX_ELEM)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          store_mode,
   input  logic [CW-1:0] elem_code,
   input  logic [1:0]    size_code,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          emit,
   output logic          accept,
   output logic [CW-1:0] beat_idx,
   output logic          mode_q,
   output logic [CW-1:0] n_q,
   output logic [1:0]    size_q
);
   import sx_pkg::*;

   xp_state_t st;

   assign in_ready = (st == ST_FILL);
   assign emit     = (st == ST_EMIT);
   assign accept   = in_ready && in_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         beat_idx <= '0;
         mode_q   <= 1'b0;
         n_q      <= '0;
         size_q   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start && size_code != SIZE_BAD) begin
               st       <= ST_FILL;
               beat_idx <= '0;
               mode_q   <= store_mode;
               n_q      <= elem_code;
               size_q   <= size_code;
            end
            ST_FILL: if (in_valid) begin
               if (beat_idx == n_q) st <= ST_EMIT;
               else                 beat_idx <= beat_idx + 1'b1;
            end
            ST_EMIT: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sx_gather.sv
`timescale 1ns/1ps
module sx_gather #(
   parameter int BEAT_W   = 64,
   parameter int MAX_ELEM = 4,
   localparam int CW = $clog2(MAX_ELEM)
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [CW-1:0]              idx,
   input  logic [BEAT_W-1:0]          din,
   output logic [MAX_ELEM*BEAT_W-1:0] img
);
   for (genvar k = 0; k < MAX_ELEM; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && idx == CW'(k)) img[k*BEAT_W +: BEAT_W] <= din;
      end
   end
endmodule

// File: rtl/sx_xlate.sv
`timescale 1ns/1ps
module sx_xlate #(
   parameter int BEAT_W   = 64,
   parameter int MAX_ELEM = 4,
   localparam int CW     = $clog2(MAX_ELEM),
   localparam int BEAT_B = BEAT_W / 8,
   localparam int TOT_B  = BEAT_B * MAX_ELEM,
   localparam int TOT_W  = TOT_B * 8
) (
   input  logic             mode,
   input  logic [CW-1:0]    n_code,
   input  logic [1:0]       size,
   input  logic [TOT_W-1:0] src,
   output logic [TOT_W-1:0] dst
);
   logic [TOT_W-1:0] cand [2][MAX_ELEM][4];

   for (genvar m = 0; m < 2; m++) begin : g_mode
      for (genvar n = 1; n <= MAX_ELEM; n++) begin : g_cnt
         for (genvar s = 0; s < 4; s++) begin : g_size
            if (s == 3) begin : g_none
               assign cand[m][n-1][s] = '0;
            end else begin : g_map
               logic [TOT_W-1:0] w;
               for (genvar g = 0; g < TOT_B; g++) begin : g_byte
                  localparam int SI = sx_pkg::src_byte(m != 0, n, 1 << s, BEAT_B, g);
                  assign w[g*8 +: 8] = src[SI*8 +: 8];
               end
               assign cand[m][n-1][s] = w;
            end
         end
      end
   end

   always_comb dst = cand[mode][n_code][size];
endmodule

// File: rtl/struct_xpose.sv
`timescale 1ns/1ps
module struct_xpose #(
   parameter int BEAT_W   = 64,
   parameter int MAX_ELEM = 4,
   localparam int CW    = $clog2(MAX_ELEM),
   localparam int TOT_W = BEAT_W * MAX_ELEM
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                store_mode,
   input  logic [CW-1:0]       elem_code,
   input  logic [1:0]          size_code,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [BEAT_W-1:0]   in_data,
   output logic [MAX_ELEM-1:0] wr_valid,
   output logic [TOT_W-1:0]    wr_data,
   output logic                done
);
   if (BEAT_W % 32 != 0) begin : g_bad_width
      $error("BEAT_W must hold a whole number of 32-bit elements");
   end
   if (MAX_ELEM < 2 || (1 << CW) != MAX_ELEM) begin : g_bad_count
      $error("MAX_ELEM must be a power of two, at least 2");
   end

   logic          emit, accept, mode_q;
   logic [CW-1:0] beat_idx, n_q;
   logic [1:0]    size_q;
   logic [TOT_W-1:0] img, perm;

   sx_ctrl #(.MAX_ELEM(MAX_ELEM)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .store_mode(store_mode),
      .elem_code(elem_code), .size_code(size_code), .in_valid(in_valid),
      .in_ready(in_ready), .emit(emit), .accept(accept), .beat_idx(beat_idx),
      .mode_q(mode_q), .n_q(n_q), .size_q(size_q)
   );

   sx_gather #(.BEAT_W(BEAT_W), .MAX_ELEM(MAX_ELEM)) u_gather (
      .clk(clk), .we(accept), .idx(beat_idx), .din(in_data), .img(img)
   );

   sx_xlate #(.BEAT_W(BEAT_W), .MAX_ELEM(MAX_ELEM)) u_xlate (
      .mode(mode_q), .n_code(n_q), .size(size_q), .src(img), .dst(perm)
   );

   for (genvar k = 0; k < MAX_ELEM; k++) begin : g_port
      logic live;
      assign live = emit && (CW'(k) <= n_q);
      assign wr_valid[k] = live;
      assign wr_data[k*BEAT_W +: BEAT_W] = live ? perm[k*BEAT_W +: BEAT_W] : '0;
   end

   assign done = emit;
endmodule

// File: rtl/sx_chk.sv
`timescale 1ns/1ps
module sx_chk #(
   parameter int MAX_ELEM = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [1:0]          size_code,
   input logic                in_valid,
   input logic                in_ready,
   input logic [MAX_ELEM-1:0] wr_valid,
   input logic                done
);
   // R2
   done_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid && in_ready));
   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   done_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);
   // R9
   strobe_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid != '0) |-> (wr_valid[0] && done));
   // R7
   bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && size_code == 2'd3 && !in_ready) |=> !in_ready);
   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (in_ready && !done));
endmodule

bind struct_xpose sx_chk #(.MAX_ELEM(MAX_ELEM)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
   .in_valid(in_valid), .in_ready(in_ready), .wr_valid(wr_valid), .done(done)
);

// File: tb/struct_xpose_test.sv
`timescale 1ns/1ps
module struct_xpose_test;
   localparam int BW = 64;
   localparam int ME = 4;
   localparam int BB = BW / 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0, start = 1'b0, store_mode = 1'b0, in_valid = 1'b0;
   logic [1:0]      elem_code = '0, size_code = '0;
   logic            in_ready, done;
   logic [BW-1:0]   in_data = '0;
   logic [ME-1:0]   wr_valid;
   logic [ME*BW-1:0] wr_data;

   int checks = 0, fails = 0;
   logic [7:0] img [ME*BB];

   struct_xpose uut (
      .clk(clk), .rst_n(rst_n), .start(start), .store_mode(store_mode),
      .elem_code(elem_code), .size_code(size_code), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .wr_valid(wr_valid),
      .wr_data(wr_data), .done(done)
   );

   task automatic chk(string rq, logic [BW-1:0] act, logic [BW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Expected output k, computed from the record layout
   function automatic logic [BW-1:0] expect_beat(bit st, int n, int sb, int k);
      logic [BW-1:0] r = '0;
      int lanes = BB / sb;
      for (int i = 0; i < lanes; i++) begin
         int srcb;
         if (!st) srcb = (i * n + k) * sb;            // record i, element k
         else begin
            int e = k * lanes + i;                    // memory element e
            srcb = ((e % n) * lanes + (e / n)) * sb;  // register e%n, lane e/n
         end
         for (int b = 0; b < sb; b++) r[(i*sb+b)*8 +: 8] = img[srcb + b];
      end
      return r;
   endfunction

   task automatic run(bit st, int n, int sz, int gap, bit poke);
      int sb = 1 << sz;
      logic [ME-1:0] mask = ME'((1 << n) - 1);
      for (int g = 0; g < ME*BB; g++) img[g] = 8'(g*29 + n*7 + sz*3 + st*5 + 1);
      @(negedge clk);
      start = 1'b1; store_mode = st; elem_code = 2'(n - 1); size_code = 2'(sz);
      @(negedge clk);
      start = 1'b0; elem_code = ~elem_code; store_mode = ~st; size_code = 2'd3;
      chk("R1 ready after start", BW'(in_ready), 1);
      for (int k = 0; k < n; k++) begin
         if (gap != 0 && k == n - 1) begin
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
            chk("R6 ready held in stall", BW'(in_ready), 1);
            chk("R6 no strobe in stall", BW'(wr_valid), 0);
         end
         if (poke && k == 0) begin
            start = 1'b1; size_code = 2'd0; elem_code = 2'd3;
         end
         in_valid = 1'b1;
         for (int b = 0; b < BB; b++) in_data[b*8 +: 8] = img[k*BB + b];
         @(negedge clk);
         start = 1'b0;
      end
      in_valid = 1'b0;
      chk("R2 strobes", BW'(wr_valid), BW'(mask));
      chk("R2 done", BW'(done), 1);
      chk("R2 ready low at emit", BW'(in_ready), 0);
      if (poke) chk("R8 latched count kept", BW'(wr_valid), BW'(mask));
      for (int k = 0; k < ME; k++) begin
         if (k >= n) chk("R9 unused output zero", wr_data[k*BW +: BW], '0);
         else if (n == 1) chk("R5 single element copy", wr_data[k*BW +: BW], expect_beat(st, n, sb, k));
         else if (!st) chk("R3 load permute", wr_data[k*BW +: BW], expect_beat(st, n, sb, k));
         else chk("R4 store permute", wr_data[k*BW +: BW], expect_beat(st, n, sb, k));
      end
      @(negedge clk);
      chk("R2 done one cycle", BW'(done), 0);
      chk("R2 strobes one cycle", BW'(wr_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset ready", BW'(in_ready), 0);
      chk("R10 reset done", BW'(done), 0);
      chk("R10 reset strobes", BW'(wr_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: rejected size code
      start = 1'b1; size_code = 2'd3; elem_code = 2'd2;
      @(negedge clk);
      start = 1'b0;
      chk("R7 bad size no ready", BW'(in_ready), 0);
      in_valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R7 bad size no strobe", BW'(wr_valid), 0);
      end
      in_valid = 1'b0;
      for (int st = 0; st < 2; st++)
         for (int n = 1; n <= ME; n++)
            for (int sz = 0; sz < 3; sz++)
               run(st[0], n, sz, (n + sz) % 3, sz == 1);
      finish_up();
   end
endmodule